// File: doc/BRIEF.md
# Command Queue Host Front End

This block sits between a 16-bit register bus and a drawing engine that consumes 32-bit commands. Software builds each command from two register writes, upper half first and lower half second. Writing the lower half places the assembled word in an on-chip queue. The engine takes words from the head of the queue through a valid/ready handshake.

Software must not overrun the queue. It reads a pending count and waits until that count is no more than the capacity minus the number of words it is about to send. The engine is idle once the pending count is zero and the engine reports no activity. A flush control discards everything still queued. An interrupt status register collects engine completion events and queue overflow. An enable register masks that status onto a single interrupt line.

Register word addresses (3-bit): 0 upper-half latch, 1 lower-half commit, 2 pending count, 3 flush, 4 interrupt status, 5 interrupt enable, 6 capacity.

Top module: `cmdq_host_if`

## Requirements
- R1: After reset the queue is empty, `cmd_valid` is 0, the pending count reads 0, interrupt status and enable read 0, `irq` is 0 and the upper-half latch reads 0.
- R2: A write to address 0 stores `reg_wdata` in the upper-half latch, which reads back at address 0. A write to address 1 enqueues `{latch, reg_wdata}`. A lower-half write with no new upper-half write reuses the last latched value.
- R3: Words leave in the order they were enqueued. `cmd_valid` is 1 exactly when the queue holds a word, the head word is on `cmd_data`, and a word is removed on a cycle with `cmd_valid` and `cmd_ready` both 1.
- R4: Address 2 reads the number of stored words plus an in-flight flag. The flag is set when the engine accepts a word. It is cleared by an `eng_done` pulse on a cycle with no acceptance.
- R5: The queue holds DEPTH words (default 512). A lower-half write at a clock edge where the queue already holds DEPTH words is dropped, even if a word leaves in that same cycle. Such a drop sets interrupt status bit 1 (overflow), which stays set until cleared.
- R6: A write to address 3 with bit 0 = 1 empties the queue in one cycle. With bit 0 = 0 the write has no effect.
- R7: Interrupt status at address 4 has bit 0 (set by `eng_done`) and bit 1 (overflow). Writing 1 to a bit clears it. A set event in the same cycle as the clear wins.
- R8: Address 5 holds a 2-bit enable written from `reg_wdata[1:0]`. `irq` is 1 exactly when some status bit and its enable bit are both 1.
- R9: Address 6 reads DEPTH-1. Addresses 1, 3 and 7 read 0. Writes to addresses 2, 6 and 7 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word address |
| reg_wdata | input | BUS_W (16) | Write data |
| reg_rdata | output | BUS_W (16) | Read data for `reg_addr`, combinational |
| cmd_valid | output | 1 | Head word available |
| cmd_ready | input | 1 | Engine accepts head word |
| cmd_data | output | 2*BUS_W (32) | Head command word |
| eng_done | input | 1 | Engine completion pulse |
| irq | output | 1 | Masked interrupt |

## Verification
Short bursts with the engine stalled show that the word is assembled from the latched upper half. A repeated lower-half write distinguishes reuse of the latch from a cleared latch. Draining with `cmd_ready` held high shows that the pending count keeps one in-flight word until `eng_done`. A fill to 513 words separates an accepted last word from a dropped one. A long random mix of writes, flushes, stalls and completion pulses, all at addresses 0 to 7, is compared each cycle against a queue-based model. It exercises simultaneous push/pop, flush during a pop and set-versus-clear collisions in the status register.

// File: rtl/cmdq_pkg.sv
package cmdq_pkg;
   localparam int REG_AW = 3;

   typedef enum logic [REG_AW-1:0] {
      RA_UPPER    = 3'd0,
      RA_LOWER    = 3'd1,
      RA_PENDING  = 3'd2,
      RA_FLUSH    = 3'd3,
      RA_IRQ_STAT = 3'd4,
      RA_IRQ_EN   = 3'd5,
      RA_CAPACITY = 3'd6
   } reg_addr_e;

   localparam int IRQ_W   = 2;
   localparam int ST_DONE = 0;
   localparam int ST_OVF  = 1;
endpackage

// File: rtl/cmdq_assembler.sv
module cmdq_assembler #(
   parameter int BUS_W = 16,
   localparam int CMD_W = 2 * BUS_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             upper_we,
   input  logic             lower_we,
   input  logic [BUS_W-1:0] wdata,
   output logic [BUS_W-1:0] upper_q,
   output logic             push,
   output logic [CMD_W-1:0] push_word
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        upper_q <= '0;
      else if (upper_we) upper_q <= wdata;
   end

   assign push      = lower_we;
   assign push_word = {upper_q, wdata};
endmodule

// File: rtl/cmdq_store.sv
module cmdq_store #(
   parameter int DEPTH = 512,
   parameter int WIDTH = 32,
   localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1,
   localparam int CNT_W = $clog2(DEPTH + 1),
   localparam bit POW2  = ((DEPTH & (DEPTH - 1)) == 0)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             push,
   input  logic [WIDTH-1:0] push_word,
   input  logic             pop,
   input  logic             flush,
   output logic             out_valid,
   output logic [WIDTH-1:0] out_word,
   output logic [CNT_W-1:0] count,
   output logic             drop
);
   logic [WIDTH-1:0] mem [DEPTH];
   logic [AW-1:0]    wr_ptr, rd_ptr, wr_nxt, rd_nxt;
   logic             full, accept;

   generate
      if (POW2) begin : g_wrap_natural
         assign wr_nxt = wr_ptr + 1'b1;
         assign rd_nxt = rd_ptr + 1'b1;
      end else begin : g_wrap_compare
         assign wr_nxt = (wr_ptr == AW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
         assign rd_nxt = (rd_ptr == AW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
      end
   endgenerate

   assign full      = (count == CNT_W'(DEPTH));
   assign accept    = push && !full && !flush;
   assign drop      = push && full && !flush;
   assign out_valid = (count != '0);
   assign out_word  = mem[rd_ptr];

   always_ff @(posedge clk) begin
      if (accept) mem[wr_ptr] <= push_word;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         count  <= '0;
      end else if (flush) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         count  <= '0;
      end else begin
         if (accept) wr_ptr <= wr_nxt;
         if (pop)    rd_ptr <= rd_nxt;
         case ({accept, pop})
            2'b10:   count <= count + 1'b1;
            2'b01:   count <= count - 1'b1;
            default: count <= count;
         endcase
      end
   end
endmodule

// File: rtl/cmdq_irq.sv
module cmdq_irq
   import cmdq_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             done_evt,
   input  logic             ovf_evt,
   input  logic             stat_we,
   input  logic             en_we,
   input  logic [IRQ_W-1:0] wbits,
   output logic [IRQ_W-1:0] status,
   output logic [IRQ_W-1:0] enable,
   output logic             irq
);
   logic [IRQ_W-1:0] set_bits, clr_bits;

   always_comb begin
      set_bits          = '0;
      set_bits[ST_DONE] = done_evt;
      set_bits[ST_OVF]  = ovf_evt;
      clr_bits          = stat_we ? wbits : '0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         status <= '0;
         enable <= '0;
      end else begin
         status <= (status & ~clr_bits) | set_bits;
         if (en_we) enable <= wbits;
      end
   end

   assign irq = |(status & enable);
endmodule

// File: rtl/cmdq_host_if.sv
module cmdq_host_if
   import cmdq_pkg::*;
#(
   parameter int DEPTH = 512,
   parameter int BUS_W = 16,
   localparam int CMD_W  = 2 * BUS_W,
   localparam int CNT_W  = $clog2(DEPTH + 1),
   localparam int PEND_W = CNT_W + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr,
   input  logic [REG_AW-1:0] reg_addr,
   input  logic [BUS_W-1:0]  reg_wdata,
   output logic [BUS_W-1:0]  reg_rdata,
   output logic              cmd_valid,
   input  logic              cmd_ready,
   output logic [CMD_W-1:0]  cmd_data,
   input  logic              eng_done,
   output logic              irq
);
   generate
      if (DEPTH < 2) begin : g_bad_depth
         $error("cmdq_host_if: DEPTH must be at least 2");
      end
      if (PEND_W > BUS_W) begin : g_bad_bus
         $error("cmdq_host_if: pending count does not fit the bus width");
      end
      if (BUS_W < IRQ_W) begin : g_bad_irqw
         $error("cmdq_host_if: bus narrower than interrupt field");
      end
   endgenerate

   localparam logic [BUS_W-1:0] CAP_VAL = BUS_W'(DEPTH - 1);

   logic             wr_upper, wr_lower, wr_flush, wr_stat, wr_en;
   logic [BUS_W-1:0] upper_q;
   logic             push, pop, drop, inflight;
   logic [CMD_W-1:0] push_word;
   logic [CNT_W-1:0] fifo_cnt;
   logic [PEND_W-1:0] pending;
   logic [IRQ_W-1:0] irq_stat, irq_en;

   assign wr_upper = reg_wr && (reg_addr == RA_UPPER);
   assign wr_lower = reg_wr && (reg_addr == RA_LOWER);
   assign wr_flush = reg_wr && (reg_addr == RA_FLUSH) && reg_wdata[0];
   assign wr_stat  = reg_wr && (reg_addr == RA_IRQ_STAT);
   assign wr_en    = reg_wr && (reg_addr == RA_IRQ_EN);
   assign pop      = cmd_valid && cmd_ready;

   cmdq_assembler #(.BUS_W(BUS_W)) u_asm (
      .clk       (clk),
      .rst_n     (rst_n),
      .upper_we  (wr_upper),
      .lower_we  (wr_lower),
      .wdata     (reg_wdata),
      .upper_q   (upper_q),
      .push      (push),
      .push_word (push_word)
   );

   cmdq_store #(.DEPTH(DEPTH), .WIDTH(CMD_W)) u_store (
      .clk       (clk),
      .rst_n     (rst_n),
      .push      (push),
      .push_word (push_word),
      .pop       (pop),
      .flush     (wr_flush),
      .out_valid (cmd_valid),
      .out_word  (cmd_data),
      .count     (fifo_cnt),
      .drop      (drop)
   );

   cmdq_irq u_irq (
      .clk      (clk),
      .rst_n    (rst_n),
      .done_evt (eng_done),
      .ovf_evt  (drop),
      .stat_we  (wr_stat),
      .en_we    (wr_en),
      .wbits    (reg_wdata[IRQ_W-1:0]),
      .status   (irq_stat),
      .enable   (irq_en),
      .irq      (irq)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        inflight <= 1'b0;
      else if (pop)      inflight <= 1'b1;
      else if (eng_done) inflight <= 1'b0;
   end

   assign pending = {1'b0, fifo_cnt} + PEND_W'(inflight);

   always_comb begin
      case (reg_addr)
         RA_UPPER:    reg_rdata = upper_q;
         RA_PENDING:  reg_rdata = BUS_W'(pending);
         RA_IRQ_STAT: reg_rdata = BUS_W'(irq_stat);
         RA_IRQ_EN:   reg_rdata = BUS_W'(irq_en);
         RA_CAPACITY: reg_rdata = CAP_VAL;
         default:     reg_rdata = '0;
      endcase
   end
endmodule

// File: rtl/cmdq_host_if_chk.sv
module cmdq_host_if_chk #(
   parameter int DEPTH = 512,
   parameter int CMD_W = 32,
   parameter int CNT_W = 10
) (
   input logic             clk,
   input logic             rst_n,
   input logic             wr_lower,
   input logic             wr_flush,
   input logic             ovf_clr,
   input logic             cmd_valid,
   input logic             cmd_ready,
   input logic [CMD_W-1:0] cmd_data,
   input logic [CNT_W-1:0] fifo_cnt,
   input logic             ovf_bit,
   input logic [1:0]       irq_en,
   input logic             irq
);
   // R5: stored words never exceed the capacity
   a_r5_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
      fifo_cnt <= CNT_W'(DEPTH));

   // R3: a stalled head word stays put
   a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && !cmd_ready && !wr_flush) |=> (cmd_valid && $stable(cmd_data)));

   // R2: a lower-half write to a non-full queue without a pop adds one word
   a_r2_push_grows: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_lower && fifo_cnt < CNT_W'(DEPTH) && !(cmd_valid && cmd_ready))
      |=> fifo_cnt == $past(fifo_cnt) + 1'b1);

   // R6: a flush leaves nothing to present
   a_r6_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
      wr_flush |=> !cmd_valid);

   // R5: overflow flag is sticky until written with one
   a_r5_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (ovf_bit && !ovf_clr) |=> ovf_bit);

   // R8: nothing enabled means no interrupt
   a_r8_masked: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_en == 2'b00) |-> !irq);
endmodule

bind cmdq_host_if cmdq_host_if_chk #(
   .DEPTH (DEPTH),
   .CMD_W (CMD_W),
   .CNT_W (CNT_W)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .wr_lower  (wr_lower),
   .wr_flush  (wr_flush),
   .ovf_clr   (wr_stat && reg_wdata[1]),
   .cmd_valid (cmd_valid),
   .cmd_ready (cmd_ready),
   .cmd_data  (cmd_data),
   .fifo_cnt  (fifo_cnt),
   .ovf_bit   (irq_stat[1]),
   .irq_en    (irq_en),
   .irq       (irq)
);

// File: tb/cmdq_host_if_tb_top.sv
`timescale 1ns/100ps
module cmdq_host_if_tb_top;
   localparam int DEPTH  = 512;
   localparam int BUS_W  = 16;
   localparam int CMD_W  = 2 * BUS_W;
   localparam real CLK_NS = 5.0;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             reg_wr = 1'b0;
   logic [2:0]       reg_addr = 3'd0;
   logic [BUS_W-1:0] reg_wdata = '0;
   logic [BUS_W-1:0] reg_rdata;
   logic             cmd_valid;
   logic             cmd_ready = 1'b0;
   logic [CMD_W-1:0] cmd_data;
   logic             eng_done = 1'b0;
   logic             irq;

   int  n_chk = 0;
   int  n_bad = 0;
   bit  finished = 1'b0;
   bit  r1_phase = 1'b1;

   always #(CLK_NS / 2.0) clk = ~clk;

   cmdq_host_if #(.DEPTH(DEPTH), .BUS_W(BUS_W)) dut_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .reg_wr    (reg_wr),
      .reg_addr  (reg_addr),
      .reg_wdata (reg_wdata),
      .reg_rdata (reg_rdata),
      .cmd_valid (cmd_valid),
      .cmd_ready (cmd_ready),
      .cmd_data  (cmd_data),
      .eng_done  (eng_done),
      .irq       (irq)
   );

   // behavioural reference model
   logic [CMD_W-1:0] m_q[$];
   logic [BUS_W-1:0] m_hi;
   bit               m_infl;
   logic [1:0]       m_stat, m_en;

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_q.delete();
         m_hi = '0; m_infl = 0; m_stat = '0; m_en = '0;
      end else begin
         int  pre;
         bit  popd, ovf;
         logic [1:0] clr;
         pre  = m_q.size();
         popd = (pre != 0) && cmd_ready;
         ovf  = 0;
         clr  = '0;
         if (reg_wr && reg_addr == 3'd3 && reg_wdata[0]) m_q.delete();
         else begin
            if (popd) void'(m_q.pop_front());
            if (reg_wr && reg_addr == 3'd1) begin
               if (pre == DEPTH) ovf = 1;
               else m_q.push_back({m_hi, reg_wdata});
            end
         end
         if (reg_wr && reg_addr == 3'd0) m_hi = reg_wdata;
         if (reg_wr && reg_addr == 3'd4) clr = reg_wdata[1:0];
         if (reg_wr && reg_addr == 3'd5) m_en = reg_wdata[1:0];
         m_stat = (m_stat & ~clr) | {ovf, eng_done};
         if (popd) m_infl = 1;
         else if (eng_done) m_infl = 0;
      end
   end

   function automatic logic [BUS_W-1:0] m_rd(input logic [2:0] a);
      case (a)
         3'd0:    return m_hi;
         3'd2:    return BUS_W'(m_q.size() + int'(m_infl));
         3'd4:    return BUS_W'(m_stat);
         3'd5:    return BUS_W'(m_en);
         3'd6:    return BUS_W'(DEPTH - 1);
         default: return '0;
      endcase
   endfunction

   function automatic string rd_tag(input logic [2:0] a);
      case (a)
         3'd0:    return "R2";
         3'd2:    return "R4/R6";
         3'd4:    return "R5/R7";
         3'd5:    return "R8";
         default: return "R9";
      endcase
   endfunction

   task automatic check(input string tag, input string what,
                        input logic [CMD_W-1:0] act, input logic [CMD_W-1:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s actual=%h expected=%h at %0t", r1_phase ? "R1" : tag,
                  what, act, exp, $time);
      end
   endtask

   // compare on every falling edge, before new inputs are driven
   always @(negedge clk) begin
      if (!finished) begin
         check("R3", "cmd_valid", CMD_W'(cmd_valid), CMD_W'(m_q.size() != 0));
         if (m_q.size() != 0) check("R2/R3", "cmd_data", cmd_data, m_q[0]);
         check(rd_tag(reg_addr), "reg_rdata", CMD_W'(reg_rdata), CMD_W'(m_rd(reg_addr)));
         check("R8", "irq", CMD_W'(irq), CMD_W'(|(m_stat & m_en)));
      end
   end

   task automatic cyc(input bit wr, input logic [2:0] a, input logic [BUS_W-1:0] d,
                      input bit rdy, input bit done);
      @(negedge clk); #1;
      reg_wr = wr; reg_addr = a; reg_wdata = d; cmd_ready = rdy; eng_done = done;
   endtask

   task automatic idle(input logic [2:0] a, input bit rdy, input int n);
      for (int i = 0; i < n; i++) cyc(0, a, '0, rdy, 0);
   endtask

   task automatic push(input logic [CMD_W-1:0] w);
      cyc(1, 3'd0, w[CMD_W-1:BUS_W], 0, 0);
      cyc(1, 3'd1, w[BUS_W-1:0], 0, 0);
   endtask

   initial begin
      // R1: reset state observed at several addresses
      repeat (3) @(negedge clk);
      #1 rst_n = 1'b1;
      idle(3'd2, 0, 1); idle(3'd4, 0, 1); idle(3'd5, 0, 1); idle(3'd0, 0, 1);
      r1_phase = 1'b0;
      // R9: capacity and unused addresses, writes to read-only ignored
      idle(3'd6, 0, 1); idle(3'd7, 0, 1); idle(3'd1, 0, 1); idle(3'd3, 0, 1);
      cyc(1, 3'd6, 16'h1234, 0, 0); cyc(1, 3'd2, 16'h00ff, 0, 0);
      cyc(1, 3'd7, 16'hffff, 0, 0); idle(3'd2, 0, 2); idle(3'd6, 0, 1);
      // R2: assembly and reuse of the latched upper half
      push(32'hA1B2_C3D4); push(32'h0102_0304); push(32'hDEAD_BEEF);
      cyc(1, 3'd1, 16'h5555, 0, 0);
      idle(3'd0, 0, 1); idle(3'd2, 0, 2);
      // R3/R4: drain, in-flight word counted until completion
      idle(3'd2, 1, 6); idle(3'd2, 0, 2);
      cyc(0, 3'd2, '0, 0, 1); idle(3'd2, 0, 1); idle(3'd4, 0, 1);
      // R7/R8: enable, W1C, set beats clear
      cyc(1, 3'd5, 16'h0001, 0, 0); idle(3'd4, 0, 1);
      cyc(1, 3'd4, 16'h0001, 0, 0); idle(3'd4, 0, 1);
      cyc(1, 3'd4, 16'h0001, 0, 1); idle(3'd4, 0, 1);
      cyc(1, 3'd4, 16'h0003, 0, 0); idle(3'd4, 0, 1);
      // R6: flush with bit 0 clear has no effect, then real flush
      push(32'h1111_0001); push(32'h2222_0002); push(32'h3333_0003);
      cyc(1, 3'd3, 16'hfffe, 0, 0); idle(3'd2, 0, 2);
      cyc(1, 3'd3, 16'h0001, 0, 0); idle(3'd2, 0, 2);
      // R5: fill to capacity, then one more
      for (int i = 0; i < DEPTH + 1; i++) push({16'(i), 16'(~i)});
      idle(3'd2, 0, 1); idle(3'd4, 0, 2);
      cyc(1, 3'd5, 16'h0002, 0, 0); idle(3'd4, 0, 1);
      // R5: push at full with a simultaneous pop is still dropped
      cyc(1, 3'd4, 16'h0002, 0, 0);
      cyc(1, 3'd0, 16'h7777, 0, 0);
      cyc(1, 3'd1, 16'h8888, 1, 0);
      idle(3'd4, 0, 1); idle(3'd2, 1, 40);
      cyc(1, 3'd3, 16'h0001, 1, 0); idle(3'd2, 0, 2);
      // mixed traffic
      for (int i = 0; i < 3000; i++) begin
         logic [31:0] r;
         r = $urandom;
         cyc(r[0] | r[1], 3'(r[4:2]), BUS_W'(r[31:16]) & ((r[4:2] == 3'd3 && r[5]) ? 16'hfffe : 16'hffff),
             r[6] | r[7], (r[11:8] == 4'h0));
      end
      idle(3'd2, 1, 20);
      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      #(CLK_NS * 150000);
      if (!finished) begin
         finished = 1'b1;
         n_chk++; n_bad++;
         $display("FAIL R3 watchdog actual=running expected=finished");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end
endmodule